// File: doc/BRIEF.md
# Variable-Length Serial Shift Register

This block is the single serial/parallel conversion register behind a serial host port that works as an SPI or I2C slave. Every transfer, inbound or outbound, passes through it. A parallel word is loaded from the port controller, shifted out most significant bit first on each shift enable, and the bits arriving on the serial input are shifted in at the same time. When the word is complete, the received data is available as a parallel word and a one-cycle completion flag is raised.

The register is always 24 bits wide. A word-length select picks 8, 16 or 24 active bits. The active window is anchored at the top of the register, so serial data always leaves from bit 23. Bits below the window are held at zero. Only the port's control logic drives the register; there is no other read or write path. Bus framing, shift clock generation and any FIFO sit outside this block.

Top module: `vlsr_top`

## Requirements
- R1: `ser_out` always equals bit 23 of the register, so each word leaves most significant bit first.
- R2: A load copies `tx_word` into the register with the bits below the active window cleared, sets the bit counter to zero and clears `xfer_done` on the next cycle.
- R3: `word_len` is encoded as 2'b00 for 8 bits (window 23..16), 2'b01 for 16 bits (window 23..8), and 2'b10 or 2'b11 for 24 bits (window 23..0).
- R4: On a shift enable without a load, the window moves up one place and `ser_in` enters at the lowest window bit (bit 16, 8 or 0). The old bit 23 is dropped.
- R5: `xfer_done` is high for exactly one cycle, in the cycle after the shift enable that completes 8, 16 or 24 shifts (per `word_len`) counted since the last load, reset or completion. It is never high otherwise.
- R6: When `load_stb` and `shift_en` are high in the same cycle, the load takes effect and the shift is discarded.
- R7: Register bits below the active window read as zero on `rx_word` from the cycle after a word length is selected, including when the length is narrowed without a load.
- R8: With neither a load nor a shift enable and an unchanged `word_len`, the register and the bit count are held.
- R9: Synchronous active-high reset clears the register, the bit count and `xfer_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| word_len | input | 2 | Word length select (R3 encoding) |
| load_stb | input | 1 | Parallel load strobe |
| tx_word | input | 24 | Parallel transmit word |
| shift_en | input | 1 | Shift enable, one bit per cycle it is high |
| ser_in | input | 1 | Serial receive data |
| ser_out | output | 1 | Serial transmit data (register bit 23) |
| rx_word | output | 24 | Register contents as parallel receive word |
| xfer_done | output | 1 | One-cycle word-complete flag |

## Verification
The assertions check several rules on every cycle. A shift must move bit 22 to the serial output. Bits outside the window must read zero one cycle after the length is chosen. A load must win over a shift. An idle cycle must hold the register. `xfer_done` may only follow a plain shift. Only the bench's cycle-by-cycle reference model can show the following: that the completion flag comes after exactly 8, 16 or 24 shifts, that the counter restarts after a load issued mid-word, and that a whole word received serially arrives intact in the correct window position. It runs each length, the 2'b11 alias, a collision between a load and a shift, and a narrowing of the length with no load.

// File: rtl/vlsr_pkg.sv
package vlsr_pkg;

    localparam int REG_W  = 24;
    localparam int SEG_W  = 8;
    localparam int CNT_W  = $clog2(REG_W + 1);
    localparam int LSB_W  = $clog2(REG_W);

    typedef enum logic [1:0] {
        WL_8   = 2'b00,
        WL_16  = 2'b01,
        WL_24  = 2'b10,
        WL_24X = 2'b11
    } wlen_e;

    typedef struct packed {
        logic load;
        logic shift;
        logic din;
    } shift_ctl_t;

    // Lowest bit of the active window for a given word length
    function automatic logic [LSB_W-1:0] win_lsb(wlen_e wl);
        case (wl)
            WL_8:    return LSB_W'(REG_W - SEG_W);
            WL_16:   return LSB_W'(REG_W - 2 * SEG_W);
            default: return '0;
        endcase
    endfunction

    // Number of bits shifted per word
    function automatic logic [CNT_W-1:0] win_bits(wlen_e wl);
        return CNT_W'(REG_W) - CNT_W'(win_lsb(wl));
    endfunction

    // One for each register bit inside the active window
    function automatic logic [REG_W-1:0] win_mask(wlen_e wl);
        return {REG_W{1'b1}} << win_lsb(wl);
    endfunction

endpackage

// File: rtl/vlsr_shreg.sv
module vlsr_shreg
    import vlsr_pkg::*;
#(
    parameter int W   = REG_W,
    parameter int LW  = LSB_W
) (
    input  logic          clk,
    input  logic          rst,
    input  shift_ctl_t    ctl,
    input  logic [LW-1:0] lsb,
    input  logic [W-1:0]  par_in,
    output logic [W-1:0]  q
);

    logic [W-1:0] d;

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic below;
        logic from_below;
        assign below = (LW'(i) < lsb);
        if (i == 0) begin : g_first
            assign from_below = ctl.din;
        end else begin : g_rest
            assign from_below = (LW'(i) == lsb) ? ctl.din : q[i-1];
        end
        always_comb begin
            if (below)
                d[i] = 1'b0;
            else if (ctl.load)
                d[i] = par_in[i];
            else if (ctl.shift)
                d[i] = from_below;
            else
                d[i] = q[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else
            q <= d;
    end

    a_r4_shift_msb_out: assert property (@(posedge clk) disable iff (rst)
        (ctl.shift && !ctl.load) |=> (q[W-1] == $past(q[W-2])));

    a_r8_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!ctl.shift && !ctl.load && $stable(lsb)) |=> $stable(q));

endmodule

// File: rtl/vlsr_bitcnt.sv
module vlsr_bitcnt
    import vlsr_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          shift,
    input  logic [CW-1:0] limit,
    output logic          done
);

    logic [CW-1:0] cnt;
    logic          last;

    assign last = (cnt >= limit - CW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            done <= 1'b0;
        end else if (load) begin
            cnt  <= '0;
            done <= 1'b0;
        end else if (shift) begin
            cnt  <= last ? '0 : cnt + CW'(1);
            done <= last;
        end else begin
            done <= 1'b0;
        end
    end

    a_r5_done_after_shift: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(shift && !load));

    a_r5_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done || $past(shift));

endmodule

// File: rtl/vlsr_top.sv
module vlsr_top
    import vlsr_pkg::*;
#(
    parameter int W  = REG_W,
    parameter int CW = CNT_W,
    parameter int LW = LSB_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [1:0]   word_len,
    input  logic         load_stb,
    input  logic [W-1:0] tx_word,
    input  logic         shift_en,
    input  logic         ser_in,
    output logic         ser_out,
    output logic [W-1:0] rx_word,
    output logic         xfer_done
);

    wlen_e         wl;
    shift_ctl_t    ctl;
    logic [LW-1:0] lsb;
    logic [CW-1:0] limit;
    logic [W-1:0]  mask;
    logic [W-1:0]  q;

    assign wl    = wlen_e'(word_len);
    assign lsb   = win_lsb(wl);
    assign limit = win_bits(wl);
    assign mask  = win_mask(wl);

    assign ctl.load  = load_stb;
    assign ctl.shift = shift_en;
    assign ctl.din   = ser_in;

    vlsr_shreg #(.W(W), .LW(LW)) u_shreg (
        .clk    (clk),
        .rst    (rst),
        .ctl    (ctl),
        .lsb    (lsb),
        .par_in (tx_word),
        .q      (q)
    );

    vlsr_bitcnt #(.CW(CW)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .load  (load_stb),
        .shift (shift_en),
        .limit (limit),
        .done  (xfer_done)
    );

    assign ser_out = q[W-1];
    assign rx_word = q;

    a_r7_outside_zero: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((rx_word & ~$past(mask)) == '0));

    a_r6_load_wins: assert property (@(posedge clk) disable iff (rst)
        load_stb |=> (rx_word == $past(tx_word & mask)));

    a_r2_load_clears_done: assert property (@(posedge clk) disable iff (rst)
        load_stb |=> !xfer_done);

endmodule

// File: tb/vlsr_top_tb_top.sv
module vlsr_top_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  word_len;
    logic        load_stb;
    logic [23:0] tx_word;
    logic        shift_en;
    logic        ser_in;
    logic        ser_out;
    logic [23:0] rx_word;
    logic        xfer_done;

    int n_vec  = 0;
    int n_fail = 0;

    logic [23:0] m_reg  = '0;
    int          m_cnt  = 0;
    logic        m_done = 1'b0;

    always #5 clk = ~clk;

    vlsr_top dut_i (
        .clk       (clk),
        .rst       (rst),
        .word_len  (word_len),
        .load_stb  (load_stb),
        .tx_word   (tx_word),
        .shift_en  (shift_en),
        .ser_in    (ser_in),
        .ser_out   (ser_out),
        .rx_word   (rx_word),
        .xfer_done (xfer_done)
    );

    function automatic int lsb_of(logic [1:0] w);
        if (w == 2'b00) return 16;
        if (w == 2'b01) return 8;
        return 0;
    endfunction

    // Behavioural model of one clock edge, then comparison after the edge
    task automatic cyc(input logic r, input logic [1:0] w, input logic ld,
                       input logic [23:0] tx, input logic sh, input logic si,
                       input string tag);
        int          lo;
        int          nb;
        logic [23:0] mk;
        @(negedge clk);
        rst = r; word_len = w; load_stb = ld; tx_word = tx;
        shift_en = sh; ser_in = si;
        @(posedge clk);
        lo = lsb_of(w);
        nb = 24 - lo;
        mk = 24'hFFFFFF << lo;
        if (r) begin
            m_reg = '0; m_cnt = 0; m_done = 1'b0;
        end else if (ld) begin
            m_reg = tx & mk; m_cnt = 0; m_done = 1'b0;
        end else if (sh) begin
            m_reg = ((m_reg << 1) | (24'(si) << lo)) & mk;
            if (m_cnt >= nb - 1) begin m_cnt = 0; m_done = 1'b1; end
            else begin m_cnt = m_cnt + 1; m_done = 1'b0; end
        end else begin
            m_reg = m_reg & mk; m_done = 1'b0;
        end
        #2;
        n_vec++;
        if (rx_word !== m_reg || ser_out !== m_reg[23] || xfer_done !== m_done) begin
            n_fail++;
            $display("FAIL %s: rx=%h so=%b done=%b expected rx=%h so=%b done=%b",
                     tag, rx_word, ser_out, xfer_done, m_reg, m_reg[23], m_done);
        end
    endtask

    task automatic word(input logic [1:0] w, input logic [23:0] tx,
                        input logic [23:0] rxpat, input string tag);
        int lo;
        lo = lsb_of(w);
        cyc(1'b0, w, 1'b1, tx, 1'b0, 1'b0, tag);
        for (int b = 23; b >= lo; b--)
            cyc(1'b0, w, 1'b0, 24'h0, 1'b1, rxpat[b], tag);
        cyc(1'b0, w, 1'b0, 24'h0, 1'b0, 1'b0, tag);
    endtask

    initial begin
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog: run=expired expected=completed");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        // R9 reset state
        cyc(1'b1, 2'b10, 1'b0, 24'h0, 1'b0, 1'b0, "R9");
        cyc(1'b1, 2'b10, 1'b1, 24'hFFFFFF, 1'b1, 1'b1, "R9");
        cyc(1'b0, 2'b10, 1'b0, 24'h0, 1'b0, 1'b0, "R9");
        // R1 R4 R5 full 24-bit word
        word(2'b10, 24'hA5C3_96, 24'h3C_5A_E1, "R1_R4_R5");
        // R3 16-bit word, window 23..8
        word(2'b01, 24'hBEEF_77, 24'h1234_00, "R3_R5");
        // R3 8-bit word, window 23..16
        word(2'b00, 24'h9F_FFFF, 24'h6B_0000, "R3_R7");
        // R3 encoding 2'b11 behaves as 24 bits
        word(2'b11, 24'h0F0F0F, 24'hF0F0F0, "R3");
        // R8 idle hold for several cycles
        cyc(1'b0, 2'b10, 1'b1, 24'h813579, 1'b0, 1'b0, "R2");
        for (int k = 0; k < 4; k++)
            cyc(1'b0, 2'b10, 1'b0, 24'h0, 1'b0, 1'b1, "R8");
        // R6 load and shift collide
        cyc(1'b0, 2'b10, 1'b0, 24'h0, 1'b1, 1'b1, "R4");
        cyc(1'b0, 2'b10, 1'b1, 24'h55AA33, 1'b1, 1'b1, "R6");
        cyc(1'b0, 2'b10, 1'b0, 24'h0, 1'b0, 1'b0, "R6");
        // R2 mid-word reload restarts the count
        cyc(1'b0, 2'b00, 1'b1, 24'hC30000, 1'b0, 1'b0, "R2");
        for (int k = 0; k < 5; k++)
            cyc(1'b0, 2'b00, 1'b0, 24'h0, 1'b1, k[0], "R2");
        cyc(1'b0, 2'b00, 1'b1, 24'h7E0000, 1'b0, 1'b0, "R2");
        for (int k = 0; k < 9; k++)
            cyc(1'b0, 2'b00, 1'b0, 24'h0, 1'b1, 1'b1, "R5");
        // R7 narrowing the length without a load clears low bits
        cyc(1'b0, 2'b10, 1'b1, 24'hDEADBE, 1'b0, 1'b0, "R7");
        cyc(1'b0, 2'b01, 1'b0, 24'h0, 1'b0, 1'b0, "R7");
        cyc(1'b0, 2'b00, 1'b0, 24'h0, 1'b0, 1'b0, "R7");
        cyc(1'b0, 2'b10, 1'b0, 24'h0, 1'b0, 1'b0, "R7");
        // back-to-back 8-bit words, done fires every eighth shift
        cyc(1'b0, 2'b00, 1'b1, 24'h010000, 1'b0, 1'b0, "R5");
        for (int k = 0; k < 20; k++)
            cyc(1'b0, 2'b00, 1'b0, 24'h0, 1'b1, k[1] ^ k[0], "R5");
        // reset in the middle of a word
        cyc(1'b0, 2'b01, 1'b1, 24'hFFFF00, 1'b0, 1'b0, "R9");
        cyc(1'b0, 2'b01, 1'b0, 24'h0, 1'b1, 1'b1, "R9");
        cyc(1'b1, 2'b01, 1'b0, 24'h0, 1'b0, 1'b0, "R9");
        cyc(1'b0, 2'b01, 1'b0, 24'h0, 1'b0, 1'b0, "R9");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule